// File: doc/BRIEF.md
# Fermat Inverter for GF(3^97)

This block computes the multiplicative inverse of a nonzero element of GF(3^97). It uses only cubing and multiplication. The field is built on the polynomial x^97 + x^12 + 2. Each coefficient takes two bits: coefficient i sits in bits [2i+1:2i] and holds 0, 1 or 2. The code 3 never appears.

The inverse is raised through a fixed chain of exponents, 1, 2, 3, 6, 12, 24, 48, 96:
- A step that doubles the exponent cubes the running value as many times as the current exponent, then multiplies by the value saved before those cubings.
- A step that adds one cubes once, then multiplies by the operand.
- The last chain value is r = a^((3^96-1)/2). One more cube gives s = r^3.

Two multiplications finish the work. In characteristic three the scalar t = s·a is its own inverse, so s·t = s²·a is the result. The block first squares s and then multiplies by the operand.

A single cube circuit and a multiplier are shared by every step:
- Each cube takes one cycle.
- Each multiplication takes one coefficient of the running value per cycle, most significant first.

In total the block performs 96 cubings and 9 multiplications.

The block is used as follows:
- The user presents an operand and pulses `start`.
- After a fixed latency, `done` pulses for one cycle with the inverse on `result`.
- `result` then stays unchanged until the next accepted start.

Top module: `gf3_inverter`

## Requirements
- R1: While reset is held and at the first cycle after reset, `done` is 0 and `result` is all zeros.
- R2: For any nonzero operand, when `done` is 1 the field product of the operand and `result` is the element 1 (bits [1:0] = 2'd1, all other bits 0). Field products are taken modulo x^97 + x^12 + 2.
- R3: For the operand 1 (bits [1:0] = 2'd1, others 0), `result` is 1.
- R4: For the operand x (bits [3:2] = 2'd1, others 0), `result` is x^96 + x^11: bits [193:192] = 2'd1 and bits [23:22] = 2'd1, all others 0.
- R5: `done` goes high exactly 978 clock edges after the edge that accepts `start` while the block is idle.
- R6: `done` is a single-cycle pulse.
- R7: A `start` raised while a computation is running is ignored. The running computation is unaffected, including the operand it works on.
- R8: While idle with `start` low, `result` holds its value, whatever `operand` does.
- R9: For the scalar operand 2 (bits [1:0] = 2'd2, others 0), `result` is 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an inversion; accepted only when idle |
| operand | input | 194 | Element to invert, sampled on the accepting edge |
| result | output | 194 | Inverse, valid from `done` until the next accepted start |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions take for granted that `start` is raised only with a nonzero operand. They also assume every coefficient code on `operand` is 0, 1 or 2, since the field arithmetic has no meaning for the code 3 or for the zero element.

The bench builds each random operand coefficient by coefficient from values reduced modulo 3. It forces coefficient 0 to be nonzero whenever a draw comes out all zero. All directed operands are written from legal codes.

The latency check counts edges from acceptance and assumes `start` is sampled once while idle. The bench lowers `start` on the cycle after the accepting edge, except in the scenario that tests a start raised during a run.

// File: rtl/gf3_inverter.sv
module gf3_inverter #(
  parameter int M   = 97,
  parameter int TAP = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [2*M-1:0]   operand,
  output logic [2*M-1:0]   result,
  output logic             done
);
  localparam int W     = 2 * M;
  localparam int IW    = $clog2(M);
  localparam int NSTEP = 9;

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_CUBE, S_MUL, S_FIN} st_t;
  typedef enum logic [1:0] {OP_A, OP_ZPRE, OP_ZPOST} op_t;

  st_t            state;
  logic [3:0]     step;
  logic [IW-1:0]  cnt;
  logic [IW-1:0]  idx;
  logic [W-1:0]   z, w, a_reg, acc;
  logic [W-1:0]   cz, mnext;
  logic           busy;

  function automatic logic [1:0] add3(input logic [1:0] x, input logic [1:0] y);
    logic [2:0] s;
    s = {1'b0, x} + {1'b0, y};
    return (s >= 3'd3) ? 2'(s - 3'd3) : s[1:0];
  endfunction

  function automatic logic [1:0] mul3(input logic [1:0] x, input logic [1:0] y);
    if (x == 2'd0 || y == 2'd0) return 2'd0;
    return (x == y) ? 2'd1 : 2'd2;
  endfunction

  function automatic logic [W-1:0] cube(input logic [W-1:0] v);
    logic [1:0] p [0:3*M-3];
    logic [W-1:0] r;
    for (int i = 0; i <= 3*M-3; i++) p[i] = 2'd0;
    for (int i = 0; i < M; i++) p[3*i] = v[2*i +: 2];
    for (int k = 3*M-3; k >= M; k--) begin
      p[k-M+TAP] = add3(p[k-M+TAP], mul3(2'd2, p[k]));
      p[k-M]     = add3(p[k-M], p[k]);
    end
    for (int i = 0; i < M; i++) r[2*i +: 2] = p[i];
    return r;
  endfunction

  function automatic logic [W-1:0] mac(input logic [W-1:0] ac, input logic [1:0] d,
                                       input logic [W-1:0] b);
    logic [W-1:0] r;
    logic [1:0]   top;
    top = ac[W-1 -: 2];
    r   = {ac[W-3:0], 2'b00};
    r[1:0]       = top;
    r[2*TAP +: 2] = add3(r[2*TAP +: 2], mul3(2'd2, top));
    for (int i = 0; i < M; i++) r[2*i +: 2] = add3(r[2*i +: 2], mul3(d, b[2*i +: 2]));
    return r;
  endfunction

  function automatic logic [IW-1:0] step_cubes(input logic [3:0] s);
    case (s)
      4'd0, 4'd1, 4'd7: return IW'(1);
      4'd2:             return IW'(3);
      4'd3:             return IW'(6);
      4'd4:             return IW'(12);
      4'd5:             return IW'(24);
      4'd6:             return IW'(48);
      default:          return IW'(0);
    endcase
  endfunction

  function automatic op_t step_op(input logic [3:0] s);
    case (s)
      4'd0, 4'd1, 4'd8: return OP_A;
      4'd7:             return OP_ZPOST;
      default:          return OP_ZPRE;
    endcase
  endfunction

  assign cz     = cube(z);
  assign mnext  = mac(acc, z[2*idx +: 2], w);
  assign busy   = (state != S_IDLE);
  assign done   = (state == S_FIN);
  assign result = z;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      step  <= '0;
      cnt   <= '0;
      idx   <= '0;
      z     <= '0;
      w     <= '0;
      a_reg <= '0;
      acc   <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          z     <= operand;
          a_reg <= operand;
          step  <= '0;
          state <= S_SETUP;
        end
        S_SETUP: begin
          w   <= (step_op(step) == OP_A) ? a_reg : z;
          cnt <= step_cubes(step);
          acc <= '0;
          idx <= IW'(M - 1);
          state <= (step_cubes(step) == '0) ? S_MUL : S_CUBE;
        end
        S_CUBE: begin
          z   <= cz;
          cnt <= cnt - 1'b1;
          if (cnt == IW'(1)) begin
            if (step_op(step) == OP_ZPOST) w <= cz;
            acc   <= '0;
            idx   <= IW'(M - 1);
            state <= S_MUL;
          end
        end
        S_MUL: begin
          acc <= mnext;
          idx <= idx - 1'b1;
          if (idx == '0) begin
            z <= mnext;
            if (step == 4'(NSTEP - 1)) state <= S_FIN;
            else begin
              step  <= step + 1'b1;
              state <= S_SETUP;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/gf3_inverter_chk.sv
module gf3_inverter_chk #(
  parameter int M = 97
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic           busy,
  input logic           done,
  input logic [2*M-1:0] result,
  input logic [2*M-1:0] a_reg
);
  localparam int LAT = 9 + (M - 1) + 9 * M;
  logic [11:0] lat;

  always_ff @(posedge clk) begin
    if (!rst_n) lat <= '0;
    else if (!busy && start) lat <= '0;
    else if (busy) lat <= lat + 1'b1;
  end

  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r5_latency: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (lat == LAT[11:0]));

  a_r7_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(a_reg));

  a_r8_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(result));

  a_r6_done_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);
endmodule

bind gf3_inverter gf3_inverter_chk #(.M(M)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
  .done(done), .result(result), .a_reg(a_reg)
);

// File: tb/gf3_inverter_bench.sv
`timescale 1ns/1ps
module gf3_inverter_bench;
  localparam int M = 97;
  localparam int TAP = 12;
  localparam int W = 2 * M;
  localparam int LAT = 978;

  logic clk = 0;
  logic rst_n = 0;
  logic start = 0;
  logic [W-1:0] operand = '0;
  logic [W-1:0] result;
  logic done;

  int checks = 0;
  int failures = 0;

  gf3_inverter u_gf3_inverter (
    .clk(clk), .rst_n(rst_n), .start(start),
    .operand(operand), .result(result), .done(done)
  );

  always #4 clk = ~clk;

  function automatic logic [W-1:0] fmul(input logic [W-1:0] a, input logic [W-1:0] b);
    int p [0:2*M-2];
    logic [W-1:0] r;
    for (int i = 0; i <= 2*M-2; i++) p[i] = 0;
    for (int i = 0; i < M; i++)
      for (int j = 0; j < M; j++)
        p[i+j] = (p[i+j] + int'(a[2*i +: 2]) * int'(b[2*j +: 2])) % 3;
    for (int k = 2*M-2; k >= M; k--) begin
      p[k-M+TAP] = (p[k-M+TAP] + 2 * p[k]) % 3;
      p[k-M]     = (p[k-M] + p[k]) % 3;
    end
    for (int i = 0; i < M; i++) r[2*i +: 2] = 2'(p[i]);
    return r;
  endfunction

  function automatic logic [W-1:0] one_elem();
    logic [W-1:0] r;
    r = '0;
    r[1:0] = 2'd1;
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_inv(input logic [W-1:0] a, output logic [W-1:0] r, output int lat);
    @(negedge clk);
    operand = a;
    start = 1;
    @(negedge clk);
    start = 0;
    lat = 0;
    forever begin
      @(negedge clk);
      lat++;
      if (done || lat > 2000) break;
    end
    r = result;
  endtask

  task automatic t_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    check(done == 1'b0, "R1 done in reset", W'(done), '0);
    check(result == '0, "R1 result in reset", result, '0);
    rst_n = 1;
    @(negedge clk);
    check(done == 1'b0 && result == '0, "R1 after reset", result, '0);
  endtask

  task automatic t_one();
    logic [W-1:0] r;
    int lat;
    run_inv(one_elem(), r, lat);
    check(r == one_elem(), "R3 inverse of 1", r, one_elem());
  endtask

  task automatic t_x();
    logic [W-1:0] r, a, e;
    int lat;
    a = '0; a[3:2] = 2'd1;
    e = '0; e[193:192] = 2'd1; e[23:22] = 2'd1;
    run_inv(a, r, lat);
    check(r == e, "R4 inverse of x", r, e);
  endtask

  task automatic t_two();
    logic [W-1:0] r, a;
    int lat;
    a = '0; a[1:0] = 2'd2;
    run_inv(a, r, lat);
    check(r == a, "R9 inverse of 2", r, a);
  endtask

  task automatic t_random(input int n);
    logic [W-1:0] r, a, pr;
    int lat;
    for (int k = 0; k < n; k++) begin
      for (int i = 0; i < M; i++) a[2*i +: 2] = 2'($urandom % 3);
      if (a == '0) a[1:0] = 2'd1;
      run_inv(a, r, lat);
      pr = fmul(a, r);
      check(pr == one_elem(), "R2 a*inv==1", pr, one_elem());
    end
  endtask

  task automatic t_latency_pulse();
    logic [W-1:0] r, a;
    int lat;
    a = '0; a[9:8] = 2'd2; a[193:192] = 2'd1;
    run_inv(a, r, lat);
    check(lat == LAT, "R5 latency", W'(lat), W'(LAT));
    @(negedge clk);
    check(done == 1'b0, "R6 done single cycle", W'(done), '0);
  endtask

  task automatic t_busy_start();
    logic [W-1:0] a, b, r, pr;
    int lat;
    a = '0; a[5:4] = 2'd1; a[51:50] = 2'd2;
    b = '0; b[1:0] = 2'd2;
    @(negedge clk);
    operand = a;
    start = 1;
    @(negedge clk);
    start = 0;
    repeat (100) @(negedge clk);
    operand = b;
    start = 1;
    repeat (3) @(negedge clk);
    start = 0;
    lat = 0;
    forever begin
      @(negedge clk);
      lat++;
      if (done || lat > 2000) break;
    end
    r = result;
    pr = fmul(a, r);
    check(pr == one_elem(), "R7 start while busy ignored", pr, one_elem());
  endtask

  task automatic t_hold();
    logic [W-1:0] r, a, keep;
    int lat;
    a = '0; a[7:6] = 2'd2; a[1:0] = 2'd1;
    run_inv(a, r, lat);
    keep = result;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      operand = ~operand;
    end
    check(result == keep, "R8 result held while idle", result, keep);
  endtask

  initial begin
    #(8 * 150000);
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_one();
    t_x();
    t_two();
    t_random(6);
    t_latency_pulse();
    t_busy_start();
    t_hold();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule